// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

A parameterised first-in first-out buffer with an independent write clock and read clock. Words written on the write side come out on the read side in the order they were written. Each pointer crosses into the other clock domain as a Gray code through a two-flop synchroniser. Every flag is computed from one local pointer and one synchronised remote pointer.

The read port has two modes, chosen by `fwft_i` while the block is in reset. In standard mode, a read edge loads the next word into `rdata_o`. In first-word-fall-through mode, an output register holds the oldest word on `rdata_o` before any read, which makes the effective depth one word larger than the RAM.

All flags are active low:
- full: the RAM holds its whole depth.
- empty: no word is ready to read.
- half-full: set from the write side and cleared from the read side. The occupancy at which it trips depends on the read mode.
- almost-empty: built in either a two-clock style or a read-clock-only style, chosen by `ae_sync_i`.

An echo read enable pulses low for each read-clock cycle in which a word leaves the FIFO. A read chip select gates all reads.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no further writes, the outputs are: `empty_no`=0, `full_no`=1, `half_full_no`=1, `almost_empty_no`=0 and `echo_ren_no`=1. Asserting `rst_ni` with data stored discards that data.
- R2: Words are read out in write order. `full_no` goes low on the write edge that stores the D-th word in the RAM (D = 2^AW). A write attempted while `full_no`=0 is ignored.
- R3: A read request while `empty_no`=0 is ignored: no word leaves the FIFO and `echo_ren_no` stays 1.
- R4: In standard mode (`fwft_i`=0), `rdata_o` changes only on a read-clock edge where a read is accepted. It then holds the oldest stored word.
- R5: In fall-through mode (`fwft_i`=1):
  - the oldest word appears on `rdata_o` with `empty_no`=1 without any read request;
  - a read edge replaces it with the next word;
  - with no reads, the FIFO accepts D+1 writes before `full_no` goes low.
- R6: In standard mode, with no reads after reset, `half_full_no` is 1 after D/2 writes. It goes low on the write edge of write D/2+1.
- R7: In fall-through mode, with no reads after reset, `half_full_no` is 1 after D/2+1 writes. It goes low on the write edge of write D/2+2, that is (E−1)/2+2 writes for the effective depth E = D+1.
- R8: `half_full_no` returns to 1 once reads bring the occupancy to or below the mode's threshold. The threshold is D/2 in standard mode and D/2+1 in fall-through mode.
- R9: In two-clock almost-empty style (`ae_sync_i`=0), `almost_empty_no` is low while the occupancy is at most AE_N. It is released on the write edge that takes the occupancy above AE_N.
- R10: In read-clock-only style (`ae_sync_i`=1), `almost_empty_no` changes only on read-clock edges. It goes low on the read edge that brings the occupancy to AE_N or below.
- R11: `echo_ren_no` is low for exactly the read-clock cycle after an edge where all three hold: `re_ni`=0, `rcs_ni`=0 and `empty_no`=1. Otherwise it is 1.
- R12: While `rcs_ni`=1, no word is read and `echo_ren_no` stays 1, whatever `re_ni` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| fwft_i | input | 1 | Read mode: 1 selects fall-through, 0 selects standard |
| ae_sync_i | input | 1 | Almost-empty style: 1 selects read-clock-only, 0 selects two-clock |
| we_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Write data |
| re_ni | input | 1 | Read enable, active low |
| rcs_ni | input | 1 | Read chip select, active low |
| rdata_o | output | DW | Read data |
| full_no | output | 1 | Full flag, active low |
| empty_no | output | 1 | Empty flag, active low |
| half_full_no | output | 1 | Half-full flag, active low |
| almost_empty_no | output | 1 | Almost-empty flag, active low |
| echo_ren_no | output | 1 | Echo read enable, active low |

## Verification
The assertions take for granted that `fwft_i` and `ae_sync_i` change only while `rst_ni` is low. They also assume that both clocks keep running, because the flags that settle through a synchroniser need edges on the far side. The stimulus changes the two mode inputs only inside its reset task. It drives both clocks continuously at unrelated periods, and applies read and write controls one nanosecond or more after the owning clock edge, so that every flag check lands after the registers have settled.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // occupancy above which the half-full flag is active
  function automatic int unsigned hf_limit(input int unsigned depth, input logic fwft);
    return fwft ? depth / 2 + 1 : depth / 2;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW   = 4,
  parameter int AE_N = 2
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        fwft_i,
  input  logic        we_ni,
  input  logic [AW:0] rptr_b_i,
  input  logic [AW:0] cptr_b_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wptr_g_o,
  output logic        wen_o,
  output logic        full_o,
  output logic        hf_o,
  output logic        ae_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr_q, wptr_nxt, wcnt_nxt;

  assign wen_o    = !we_ni && !full_o;
  assign wptr_nxt = wptr_q + PW'(wen_o);
  assign wcnt_nxt = wptr_nxt - cptr_b_i;  // conservative high: remote pointer lags
  assign waddr_o  = wptr_q[AW-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      wptr_g_o <= '0;
      full_o   <= 1'b0;
      hf_o     <= 1'b0;
      ae_o     <= 1'b1;
    end else begin
      wptr_q   <= wptr_nxt;
      wptr_g_o <= wptr_nxt ^ (wptr_nxt >> 1);
      full_o   <= (wptr_nxt - rptr_b_i) == PW'(DEPTH);
      hf_o     <= wcnt_nxt > PW'(dcf_pkg::hf_limit(DEPTH, fwft_i));
      ae_o     <= wcnt_nxt <= PW'(AE_N);
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW   = 4,
  parameter int AE_N = 2
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          re_ni,
  input  logic          rcs_ni,
  input  logic [AW:0]   wptr_b_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_g_o,
  output logic [AW:0]   cptr_g_o,
  output logic          mem_rd_o,
  output logic          empty_no,
  output logic          echo_ren_no,
  output logic          hf_o,
  output logic          ae_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rptr_q, rptr_nxt, cptr_q, cptr_nxt, rcnt_nxt;
  logic          ram_empty_q, ov_q, ov_nxt, rd_req, take, pop;

  assign rd_req = !re_ni && !rcs_ni;

  always_comb begin
    if (fwft_i) begin
      pop    = rd_req && ov_q;
      take   = !ram_empty_q && (!ov_q || pop);
      ov_nxt = take || (ov_q && !pop);
    end else begin
      take   = rd_req && !ram_empty_q;
      pop    = take;
      ov_nxt = 1'b0;
    end
  end

  assign rptr_nxt = rptr_q + PW'(take);
  // consumed pointer: words that have left the whole FIFO, output stage included
  assign cptr_nxt = fwft_i ? cptr_q + PW'(pop) : rptr_nxt;
  assign rcnt_nxt = wptr_b_i - cptr_nxt;  // conservative low: remote pointer lags
  assign raddr_o  = rptr_q[AW-1:0];
  assign mem_rd_o = take;
  assign empty_no = fwft_i ? ov_q : !ram_empty_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rptr_g_o    <= '0;
      cptr_q      <= '0;
      cptr_g_o    <= '0;
      ram_empty_q <= 1'b1;
      ov_q        <= 1'b0;
      echo_ren_no <= 1'b1;
      hf_o        <= 1'b0;
      ae_o        <= 1'b1;
    end else begin
      rptr_q      <= rptr_nxt;
      rptr_g_o    <= rptr_nxt ^ (rptr_nxt >> 1);
      cptr_q      <= cptr_nxt;
      cptr_g_o    <= cptr_nxt ^ (cptr_nxt >> 1);
      ram_empty_q <= rptr_nxt == wptr_b_i;
      ov_q        <= ov_nxt;
      echo_ren_no <= !pop;
      hf_o        <= rcnt_nxt > PW'(dcf_pkg::hf_limit(DEPTH, fwft_i));
      ae_o        <= rcnt_nxt <= PW'(AE_N);
    end
  end
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int AE_N = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ae_sync_i,
  input  logic          we_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_ni,
  input  logic          rcs_ni,
  output logic [DW-1:0] rdata_o,
  output logic          full_no,
  output logic          empty_no,
  output logic          half_full_no,
  output logic          almost_empty_no,
  output logic          echo_ren_no
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_g, rptr_g, cptr_g, wptr_b_r, rptr_b_w, cptr_b_w;
  logic          wen, mem_rd, full_w, hf_w, ae_w, hf_r, ae_r;

  dcf_wr_ctl #(.AW(AW), .AE_N(AE_N)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .we_ni(we_ni),
    .rptr_b_i(rptr_b_w), .cptr_b_i(cptr_b_w), .waddr_o(waddr), .wptr_g_o(wptr_g),
    .wen_o(wen), .full_o(full_w), .hf_o(hf_w), .ae_o(ae_w)
  );

  dcf_rd_ctl #(.AW(AW), .AE_N(AE_N)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .re_ni(re_ni), .rcs_ni(rcs_ni),
    .wptr_b_i(wptr_b_r), .raddr_o(raddr), .rptr_g_o(rptr_g), .cptr_g_o(cptr_g),
    .mem_rd_o(mem_rd), .empty_no(empty_no), .echo_ren_no(echo_ren_no),
    .hf_o(hf_r), .ae_o(ae_r)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wptr_g), .bin_o(wptr_b_r));
  dcf_sync #(.W(PW)) u_sync_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rptr_g), .bin_o(rptr_b_w));
  dcf_sync #(.W(PW)) u_sync_c2w (.clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(cptr_g), .bin_o(cptr_b_w));

  always_ff @(posedge wclk_i) begin
    if (wen) mem_q[waddr] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (mem_rd) rdata_o <= mem_q[raddr];
  end

  assign full_no      = !full_w;
  // set by the write side at once; release needs both views at or below threshold
  assign half_full_no = !(hf_w || hf_r);
  // two-clock style: the write side releases at once, assertion needs both views
  assign almost_empty_no = ae_sync_i ? !ae_r : !(ae_r && ae_w);
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          we_ni,
  input logic          re_ni,
  input logic          rcs_ni,
  input logic [DW-1:0] rdata_o,
  input logic          full_no,
  input logic          empty_no,
  input logic          echo_ren_no,
  input logic [AW-1:0] waddr_i
);
  // R2
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!full_no && !we_ni) |=> $stable(waddr_i));

  // R3
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> echo_ren_no);

  // R11
  echo_cause_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !echo_ren_no |-> $past(!re_ni && !rcs_ni && empty_no));

  // R12
  cs_block_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rcs_ni |=> echo_ren_no);

  // R4
  std_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !(!re_ni && !rcs_ni && empty_no)) |=> $stable(rdata_o));

  // R5
  fwft_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft_i && empty_no && (re_ni || rcs_ni)) |=> (empty_no && $stable(rdata_o)));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i),
  .we_ni(we_ni), .re_ni(re_ni), .rcs_ni(rcs_ni), .rdata_o(rdata_o),
  .full_no(full_no), .empty_no(empty_no), .echo_ren_no(echo_ren_no),
  .waddr_i(waddr)
);

// File: tb/tb_dcfifo_flags.sv
`timescale 1ns/1ps
module tb_dcfifo_flags;
  localparam int DW = 8, AW = 4, DEPTH = 16, AE_N = 2;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft = 0, ae_sync = 0;
  logic we_n = 1, re_n = 1, rcs_n = 1;
  logic [DW-1:0] wdata = '0, rdata;
  logic full_n, empty_n, hf_n, ae_n, echo_n;

  always #2.5 wclk = ~wclk;
  always #3.7 rclk = ~rclk;

  dcfifo_flags #(.DW(DW), .AW(AW), .AE_N(AE_N)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft), .ae_sync_i(ae_sync),
    .we_ni(we_n), .wdata_i(wdata), .re_ni(re_n), .rcs_ni(rcs_n), .rdata_o(rdata),
    .full_no(full_n), .empty_no(empty_n), .half_full_no(hf_n),
    .almost_empty_no(ae_n), .echo_ren_no(echo_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  bit pred = 0, manual = 0;
  int rd_pct = 0, cs_hi_pct = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(input string tag);
    if (exp_q.size() == 0) chk({tag, " (read with nothing expected)"}, 1, 0);
    else begin
      chk(tag, rdata, exp_q[0]);
      void'(exp_q.pop_front());
    end
  endtask

  // reader driver
  always @(posedge rclk) begin
    #1;
    if (!manual) begin
      re_n  = !($urandom_range(99) < rd_pct);
      rcs_n = ($urandom_range(99) < cs_hi_pct);
    end
  end

  // monitor: predicts reads and echo pulses, compares data
  always @(negedge rclk) begin
    if (!rst_n) pred = 0;
    else begin
      chk("R11 echo read enable", echo_n, !pred);
      if (pred && !fwft) pop_cmp("R4 R2 standard read data");
      if (!re_n && !rcs_n && empty_n) begin
        if (fwft) pop_cmp("R5 R2 fall-through read data");
        pred = 1;
      end else pred = 0;
    end
  end

  task automatic wr(input logic [DW-1:0] d);
    bit ok;
    ok = full_n;
    we_n = 0; wdata = d;
    @(posedge wclk); #1;
    we_n = 1;
    if (ok) exp_q.push_back(d);
  endtask

  task automatic do_reset(input bit fw, input bit aes);
    rst_n = 0; we_n = 1; manual = 0; rd_pct = 0; cs_hi_pct = 0;
    fwft = fw; ae_sync = aes;
    repeat (3) @(posedge wclk);
    exp_q.delete();
    rst_n = 1;
    repeat (3) @(posedge wclk);
    #1;
  endtask

  task automatic drain();
    rd_pct = 100; cs_hi_pct = 0;
    while (exp_q.size() != 0) @(posedge wclk);
    repeat (20) @(posedge wclk);
    rd_pct = 0;
    repeat (10) @(posedge wclk);
    #1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // phase A: standard mode, two-clock almost-empty
    do_reset(0, 0);
    chk("R1 empty after reset", empty_n, 0);
    chk("R1 full after reset", full_n, 1);
    chk("R1 half-full after reset", hf_n, 1);
    chk("R1 almost-empty after reset", ae_n, 0);
    chk("R1 echo after reset", echo_n, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      wr(DW'(k));
      chk("R6 half-full trip in standard mode", hf_n, (k >= DEPTH / 2 + 1) ? 0 : 1);
      chk("R2 full flag", full_n, (k == DEPTH) ? 0 : 1);
      if (k <= AE_N + 1) chk("R9 almost-empty released on write edge", ae_n, (k == AE_N + 1) ? 1 : 0);
    end
    wr(8'hEE);
    chk("R2 write while full", full_n, 0);
    manual = 1;
    @(posedge rclk); #2; re_n = 0; rcs_n = 1;
    repeat (20) @(posedge rclk);
    #2; re_n = 1; manual = 0;
    chk("R12 chip select blocks reads", exp_q.size(), DEPTH);
    drain();
    chk("R8 half-full released after drain", hf_n, 1);
    chk("R9 almost-empty reasserted", ae_n, 0);
    chk("R3 empty after drain", empty_n, 0);
    rd_pct = 100;
    repeat (20) @(posedge wclk);
    rd_pct = 0; #1;
    chk("R3 read while empty ignored", empty_n, 0);
    chk("R3 no data appeared", exp_q.size(), 0);

    // phase B: read-clock-only almost-empty
    do_reset(0, 1);
    for (int k = 1; k <= AE_N + 1; k++) wr(DW'(8'h30 + k));
    chk("R10 almost-empty not moved by write edge", ae_n, 0);
    repeat (10) @(posedge wclk); #1;
    chk("R10 almost-empty released via read clock", ae_n, 1);
    manual = 1;
    @(posedge rclk); #2; re_n = 0; rcs_n = 0;
    @(posedge rclk); #2; re_n = 1; rcs_n = 1;
    chk("R10 almost-empty on read edge", ae_n, 0);
    manual = 0;
    drain();

    // phase C: fall-through mode
    do_reset(1, 0);
    wr(8'hA0);
    repeat (20) @(posedge wclk); #1;
    chk("R5 word visible without read", empty_n, 1);
    chk("R5 first word on output", rdata, 8'hA0);
    chk("R7 half-full idle", hf_n, 1);
    for (int k = 2; k <= DEPTH + 1; k++) begin
      wr(DW'(8'hA0 + k));
      chk("R7 half-full trip in fall-through mode", hf_n, (k >= DEPTH / 2 + 2) ? 0 : 1);
      chk("R5 full at depth plus one", full_n, (k == DEPTH + 1) ? 0 : 1);
    end
    drain();
    chk("R8 half-full released in fall-through", hf_n, 1);
    chk("R5 empty after drain", empty_n, 0);

    // phase D: random streams in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0], m[0]);
      rd_pct = 50; cs_hi_pct = 20;
      for (int i = 0; i < 200; i++) begin
        if ($urandom_range(2) != 0) wr(DW'(i));
        else begin @(posedge wclk); #1; end
      end
      drain();
      chk("R2 stream fully delivered", exp_q.size(), 0);
      chk("R8 half-full after stream", hf_n, 1);
    end

    // phase E: reset with data stored
    do_reset(0, 0);
    for (int k = 0; k < 5; k++) wr(DW'(8'h50 + k));
    rst_n = 0; #1;
    chk("R1 reset clears empty", empty_n, 0);
    chk("R1 reset clears almost-empty", ae_n, 0);
    chk("R1 reset clears full", full_n, 1);
    chk("R1 reset clears half-full", hf_n, 1);
    exp_q.delete();
    repeat (3) @(posedge wclk);
    rst_n = 1;
    repeat (20) @(posedge wclk); #1;
    chk("R1 stays empty after release", empty_n, 0);

    summary();
    $finish;
  end
endmodule